// File: doc/BRIEF.md
# Matrix Index Remap Schedule Generator

This block turns a plain linear element loop into a walk over a one-, two- or three-dimensional array that stays in place in a register file. Each dimension can have any size from 1 to 128, so prime shapes such as 5x7 work as easily as power-of-two shapes. A walk-order code picks which dimension steps fastest, which gives a transpose without copying the data. A mirror bit per dimension walks that dimension backwards, and a mirror combined with a swapped order gives a rotation. A skip mode removes dimensions from the computed index, which gives repeating or modulo sequences.

After a start pulse the block latches its configuration. It then emits one register number per handshake and marks the final element with a last flag. The schedule depends only on the configuration, never on data, so a scheduler placed between decode and issue can know the whole sequence ahead of time.

Top module: `mrs_remap_sched`

## Requirements
- R1: After reset, out_valid is low, and it stays low until a start is accepted.
- R2: A start pulse while idle with vl nonzero latches every configuration input, and out_valid is high from the next cycle on. A start with vl equal to zero is ignored, and out_valid stays low.
- R3: Each output is out_reg = (base_reg + reg_offset + idx) mod 2^REG_W. idx is the sum over the kept dimensions d of pos_d * w_d. The dimensions are numbered x=0, y=1, z=2, and field d of dim_m1 holds size_d - 1. The weight w_x is 1, w_y is the kept size of x, and w_z is the product of the kept sizes of x and y. A dropped dimension contributes a size of 1 to the weights of the dimensions above it.
- R4: Walk levels count by comparing against the stored size minus one, so a level rolls over after exactly size_d steps for any size. Level 0 steps on every transfer, and each higher level steps when all levels below it roll over.
- R5: walk_order picks the dimension at levels 0/1/2: 0 gives x,y,z; 1 gives y,x,z; 2 gives x,z,y; 3 gives z,x,y; 4 gives y,z,x; 5 gives z,y,x. Codes 6 and 7 behave like 0.
- R6: When mirror[d] is 1, the position of dimension d is size_d - 1 minus its level count. When mirror[d] is 0, the position equals the count.
- R7: skip_mode sets which dimensions are kept: 0 keeps all three; 1 drops x; 2 drops z; 3 keeps x only. On a 3x3 walk, mode 1 gives 0 0 0 1 1 1 2 2 2, and mode 3 gives 0 1 2 0 1 2 0 1 2.
- R8: A run delivers exactly min(vl, size_x*size_y*size_z) elements. out_last is high on the final element only.
- R9: While out_valid is high and out_ready is low, out_reg and out_last hold their values. The walk advances only on a cycle where valid and ready are both high.
- R10: A start during an active run is ignored, and so is any change to the configuration inputs. No second run follows.
- R11: The cycle after the last element is transferred, out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a run when idle |
| vl | input | CNT_W | Maximum element count for the run |
| dim_m1 | input | 3 x CNT_W | Size minus one for x, y, z |
| walk_order | input | 3 | Walk-order code |
| mirror | input | 3 | Reverse-walk bit per dimension |
| skip_mode | input | 2 | Dimension drop mode |
| base_reg | input | REG_W | Base register number |
| reg_offset | input | REG_W | Runtime offset added to every index |
| out_ready | input | 1 | Consumer accepts the current element |
| out_valid | output | 1 | An element is presented |
| out_reg | output | REG_W | Register number for the current element |
| out_last | output | 1 | Current element is the final one |

## Verification
The hardest situation to reach is a start pulse, together with changed configuration inputs, arriving in the middle of a run that the consumer is also stalling. Nothing at the ports shows that such a pulse was dropped unless the rest of the sequence still matches the first configuration and no second run appears afterwards. The bench sweeps all six walk orders over a 2x3x4 shape with mirroring and skipping, runs prime shapes with the order transposed and rotated, and cuts a 128-element shape short with vl = 127. In one run it raises start with a different configuration at the third element, under pseudo-random backpressure, and then checks that out_valid stays low after the final element.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

  localparam int unsigned NDIM = 3;

  typedef logic [1:0] dim_sel_t;

  // Dimension walked at a given level (0 = fastest) for a walk-order code.
  function automatic dim_sel_t walk_dim(input logic [2:0] order, input int lvl);
    logic [5:0] tbl;
    case (order)
      3'd1:    tbl = {2'd2, 2'd0, 2'd1};
      3'd2:    tbl = {2'd1, 2'd2, 2'd0};
      3'd3:    tbl = {2'd1, 2'd0, 2'd2};
      3'd4:    tbl = {2'd0, 2'd2, 2'd1};
      3'd5:    tbl = {2'd0, 2'd1, 2'd2};
      default: tbl = {2'd2, 2'd1, 2'd0};
    endcase
    return tbl[lvl*2 +: 2];
  endfunction

  // Dimensions kept in the index (bit0 = x, bit1 = y, bit2 = z).
  function automatic logic [2:0] keep_mask(input logic [1:0] skip);
    case (skip)
      2'd1:    return 3'b110;
      2'd2:    return 3'b011;
      2'd3:    return 3'b001;
      default: return 3'b111;
    endcase
  endfunction

endpackage

// File: rtl/mrs_walk_ctr.sv
module mrs_walk_ctr #(
  parameter int unsigned CNT_W = 7
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            clear,
  input  logic                            advance,
  input  logic [mrs_pkg::NDIM-1:0][CNT_W-1:0] lim,
  output logic [mrs_pkg::NDIM-1:0][CNT_W-1:0] cnt,
  output logic [mrs_pkg::NDIM-1:0]        lvl_max,
  output logic                            all_max
);
  localparam int unsigned NL = mrs_pkg::NDIM;

  logic [NL-1:0] carry;

  for (genvar l = 0; l < NL; l++) begin : g_lvl
    assign lvl_max[l] = (cnt[l] == lim[l]);
    if (l == 0) begin : g_first
      assign carry[l] = advance;
    end else begin : g_next
      assign carry[l] = carry[l-1] & lvl_max[l-1];
    end
    always_ff @(posedge clk) begin
      if (!rst_n || clear) cnt[l] <= '0;
      else if (carry[l])   cnt[l] <= lvl_max[l] ? '0 : cnt[l] + 1'b1;
    end
  end

  assign all_max = &lvl_max;

endmodule

// File: rtl/mrs_index.sv
module mrs_index #(
  parameter int unsigned CNT_W = 7,
  parameter int unsigned REG_W = 7
) (
  input  logic [mrs_pkg::NDIM-1:0][CNT_W-1:0] cnt,
  input  logic [mrs_pkg::NDIM-1:0][CNT_W-1:0] dim_m1,
  input  logic [2:0]                      order,
  input  logic [2:0]                      mirror,
  input  logic [1:0]                      skip,
  input  logic [REG_W-1:0]                base,
  input  logic [REG_W-1:0]                offset,
  output logic [REG_W-1:0]                reg_num
);
  localparam int unsigned NL = mrs_pkg::NDIM;

  function automatic logic [REG_W-1:0] span_of(input logic kept, input logic [CNT_W-1:0] m1);
    return kept ? REG_W'(m1) + REG_W'(1) : REG_W'(1);
  endfunction

  logic [NL-1:0][CNT_W-1:0] pos;
  logic [NL-1:0][REG_W-1:0] wgt;
  logic [2:0]               keep;
  logic [REG_W-1:0]         span;
  logic [REG_W-1:0]         acc;

  always_comb begin
    pos  = '0;
    keep = mrs_pkg::keep_mask(skip);
    for (int l = 0; l < NL; l++) begin
      mrs_pkg::dim_sel_t d;
      d = mrs_pkg::walk_dim(order, l);
      pos[d] = mirror[d] ? dim_m1[d] - cnt[l] : cnt[l];
    end
    span = REG_W'(1);
    for (int d = 0; d < NL; d++) begin
      wgt[d] = keep[d] ? span : '0;
      span   = span * span_of(keep[d], dim_m1[d]);
    end
    acc = base + offset;
    for (int d = 0; d < NL; d++) begin
      acc = acc + REG_W'(pos[d]) * wgt[d];
    end
    reg_num = acc;
  end

endmodule

// File: rtl/mrs_remap_sched.sv
module mrs_remap_sched #(
  parameter int unsigned CNT_W = 7,
  parameter int unsigned REG_W = 7
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start,
  input  logic [CNT_W-1:0]                vl,
  input  logic [mrs_pkg::NDIM-1:0][CNT_W-1:0] dim_m1,
  input  logic [2:0]                      walk_order,
  input  logic [2:0]                      mirror,
  input  logic [1:0]                      skip_mode,
  input  logic [REG_W-1:0]                base_reg,
  input  logic [REG_W-1:0]                reg_offset,
  input  logic                            out_ready,
  output logic                            out_valid,
  output logic [REG_W-1:0]                out_reg,
  output logic                            out_last
);
  localparam int unsigned NL = mrs_pkg::NDIM;

  // latched configuration
  logic [CNT_W-1:0]         vl_q;
  logic [NL-1:0][CNT_W-1:0] dim_m1_q;
  logic [2:0]               order_q;
  logic [2:0]               mirror_q;
  logic [1:0]               skip_q;
  logic [REG_W-1:0]         base_q;
  logic [REG_W-1:0]         off_q;

  logic                     active_q;
  logic [CNT_W-1:0]         step_q;

  // named internal events
  logic                     accept;
  logic                     fire;
  logic                     step_end;
  logic                     ctr_all_max;
  logic [NL-1:0]            ctr_lvl_max;
  logic [NL-1:0][CNT_W-1:0] ctr_cnt;
  logic [NL-1:0][CNT_W-1:0] lvl_lim;

  assign accept   = start && !active_q && (vl != '0);
  assign fire     = active_q && out_ready;
  assign step_end = (step_q == vl_q - 1'b1);

  for (genvar l = 0; l < NL; l++) begin : g_lim
    assign lvl_lim[l] = dim_m1_q[mrs_pkg::walk_dim(order_q, l)];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      step_q   <= '0;
      vl_q     <= '0;
      dim_m1_q <= '0;
      order_q  <= '0;
      mirror_q <= '0;
      skip_q   <= '0;
      base_q   <= '0;
      off_q    <= '0;
    end else if (accept) begin
      active_q <= 1'b1;
      step_q   <= '0;
      vl_q     <= vl;
      dim_m1_q <= dim_m1;
      order_q  <= walk_order;
      mirror_q <= mirror;
      skip_q   <= skip_mode;
      base_q   <= base_reg;
      off_q    <= reg_offset;
    end else if (fire) begin
      step_q <= step_q + 1'b1;
      if (out_last) active_q <= 1'b0;
    end
  end

  mrs_walk_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept),
    .advance (fire),
    .lim     (lvl_lim),
    .cnt     (ctr_cnt),
    .lvl_max (ctr_lvl_max),
    .all_max (ctr_all_max)
  );

  mrs_index #(.CNT_W(CNT_W), .REG_W(REG_W)) u_idx (
    .cnt     (ctr_cnt),
    .dim_m1  (dim_m1_q),
    .order   (order_q),
    .mirror  (mirror_q),
    .skip    (skip_q),
    .base    (base_q),
    .offset  (off_q),
    .reg_num (out_reg)
  );

  assign out_valid = active_q;
  assign out_last  = active_q && (step_end || ctr_all_max);

endmodule

// File: rtl/mrs_sched_chk.sv
module mrs_sched_chk #(
  parameter int unsigned CNT_W = 7,
  parameter int unsigned REG_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [CNT_W-1:0] vl,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_last,
  input logic [REG_W-1:0] out_reg,
  input logic             accept,
  input logic             fire,
  input logic [CNT_W-1:0] cnt0,
  input logic             lvl_max0
);
  logic [CNT_W-1:0] hs_cnt;
  logic [CNT_W-1:0] vl_lat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_cnt <= '0;
      vl_lat <= '0;
    end else if (accept) begin
      hs_cnt <= '0;
      vl_lat <= vl;
    end else if (fire) begin
      hs_cnt <= hs_cnt + 1'b1;
    end
  end

  // R2
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_reg) && $stable(out_last)));

  // R8
  vl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (hs_cnt < vl_lat));

  // R8
  last_at_vl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (hs_cnt == vl_lat - 1'b1)) |-> out_last);

  // R4
  inner_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !out_last && lvl_max0) |=> (cnt0 == '0));

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && out_valid) |-> !accept);

  // R11
  drop_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && out_last) |=> !out_valid);

endmodule

bind mrs_remap_sched mrs_sched_chk #(.CNT_W(CNT_W), .REG_W(REG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .vl        (vl),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_last  (out_last),
  .out_reg   (out_reg),
  .accept    (accept),
  .fire      (fire),
  .cnt0      (ctr_cnt[0]),
  .lvl_max0  (ctr_lvl_max[0])
);

// File: tb/test_mrs_remap_sched.sv
module test_mrs_remap_sched;
  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [6:0]       vl = '0;
  logic [2:0][6:0]  dim_m1 = '0;
  logic [2:0]       walk_order = '0;
  logic [2:0]       mirror = '0;
  logic [1:0]       skip_mode = '0;
  logic [6:0]       base_reg = '0;
  logic [6:0]       reg_offset = '0;
  logic             out_ready = 1'b0;
  logic             out_valid;
  logic [6:0]       out_reg;
  logic             out_last;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] lfsr = 8'hA5;

  int c_m1[3];
  int c_order, c_mir, c_skip, c_base, c_off, c_vl;

  always #5 clk = ~clk;

  mrs_remap_sched i_mrs_remap_sched (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .dim_m1(dim_m1),
    .walk_order(walk_order), .mirror(mirror), .skip_mode(skip_mode),
    .base_reg(base_reg), .reg_offset(reg_offset), .out_ready(out_ready),
    .out_valid(out_valid), .out_reg(out_reg), .out_last(out_last)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_len();
    int p = (c_m1[0] + 1) * (c_m1[1] + 1) * (c_m1[2] + 1);
    return (c_vl < p) ? c_vl : p;
  endfunction

  // expected register number for element i, by division rather than counting
  function automatic int exp_reg(input int i);
    int n[3], wd[3], c[3], pos[3], kp[3];
    int acc, span;
    for (int d = 0; d < 3; d++) n[d] = c_m1[d] + 1;
    case (c_order)
      1: wd = '{1, 0, 2};
      2: wd = '{0, 2, 1};
      3: wd = '{2, 0, 1};
      4: wd = '{1, 2, 0};
      5: wd = '{2, 1, 0};
      default: wd = '{0, 1, 2};
    endcase
    c[0] = i % n[wd[0]];
    c[1] = (i / n[wd[0]]) % n[wd[1]];
    c[2] = i / (n[wd[0]] * n[wd[1]]);
    for (int l = 0; l < 3; l++)
      pos[wd[l]] = c_mir[wd[l]] ? n[wd[l]] - 1 - c[l] : c[l];
    case (c_skip)
      1: kp = '{0, 1, 1};
      2: kp = '{1, 1, 0};
      3: kp = '{1, 0, 0};
      default: kp = '{1, 1, 1};
    endcase
    acc = 0; span = 1;
    for (int d = 0; d < 3; d++)
      if (kp[d] != 0) begin acc += pos[d] * span; span *= n[d]; end
    return (c_base + c_off + acc) % 128;
  endfunction

  task automatic run_case(input string req, input int mx, input int my, input int mz,
                          input int ord, input int mir, input int skp, input int bas,
                          input int off, input int len, input bit full_ready, input bit poke);
    int k = 0;
    bit done = 0;
    bit stalled = 0;
    int held = 0;
    c_m1 = '{mx, my, mz}; c_order = ord; c_mir = mir; c_skip = skp;
    c_base = bas; c_off = off; c_vl = len;
    @(negedge clk);
    dim_m1 = {7'(mz), 7'(my), 7'(mx)};
    walk_order = 3'(ord); mirror = 3'(mir); skip_mode = 2'(skp);
    base_reg = 7'(bas); reg_offset = 7'(off); vl = 7'(len);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R2: valid the cycle after acceptance
    check(out_valid == 1'b1, "R2 launch", out_valid, 1);
    while (!done) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = full_ready | lfsr[0] | lfsr[2];
      if (stalled) begin
        // R9: held while not accepted
        check(out_valid && out_reg == 7'(held), "R9 hold", out_reg, held);
      end
      if (out_valid && out_ready) begin
        check(out_reg == 7'(exp_reg(k)), {req, " index"}, out_reg, exp_reg(k));
        // R8: last only on final element
        check(out_last == (k == exp_len() - 1), "R8 last", out_last, k == exp_len() - 1);
        if (out_last || k >= exp_len() - 1) done = 1;
        k++;
        stalled = 0;
      end else begin
        stalled = out_valid;
        held = out_reg;
      end
      if (poke && k == 2 && !done) begin
        // R10: different configuration during the run
        start = 1'b1; vl = 7'd3; walk_order = 3'd5; mirror = 3'b111; base_reg = 7'd99;
      end else start = 1'b0;
      @(negedge clk);
      if (!out_valid && !done) begin
        check(0, "R8 early end", k, exp_len());
        done = 1;
      end
    end
    start = 1'b0;
    out_ready = 1'b0;
    // R11: valid drops right after final transfer
    check(out_valid == 1'b0, "R11 drop", out_valid, 0);
    check(k == exp_len(), "R8 length", k, exp_len());
    repeat (3) @(negedge clk);
    // R10: no second run launched
    check(out_valid == 1'b0, "R10 no relaunch", out_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: idle out of reset
    check(out_valid == 1'b0, "R1 reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 idle", out_valid, 0);

    // R7: repeat and modulo sequences on a 3x3 walk
    run_case("R7 repeat", 2, 2, 0, 0, 0, 1, 0, 0, 9, 0, 0);
    run_case("R7 modulo", 2, 2, 0, 0, 0, 3, 0, 0, 9, 0, 0);
    // R3 R4: prime shape, linear walk
    run_case("R3 5x7", 4, 6, 0, 0, 0, 0, 0, 0, 127, 0, 0);
    // R5: transpose by order
    run_case("R5 transpose", 4, 6, 0, 1, 0, 0, 0, 0, 127, 1, 0);
    // R6: rotation = swapped order plus mirror, with base and offset
    run_case("R6 rotate", 4, 6, 0, 1, 1, 0, 5, 3, 127, 0, 0);
    // R5 R6 R7: all orders on a 3D shape
    for (int o = 0; o < 8; o++)
      run_case("R5 order3d", 1, 2, 3, o, 5, 2, 0, 0, 127, 0, 0);
    // R8: vl shorter than shape, with a start poke mid-run (R10)
    run_case("R10 poke", 4, 6, 0, 0, 0, 0, 10, 0, 10, 0, 1);
    // R8 R3: 128-element shape cut by vl = 127, index wraps mod 128
    run_case("R8 vl127", 7, 15, 0, 0, 0, 0, 40, 7, 127, 0, 0);
    // R6: full mirror of a 3D shape
    run_case("R6 mirror3d", 2, 4, 1, 3, 7, 0, 0, 0, 127, 1, 0);
    // R4: single-element shape
    run_case("R4 single", 0, 0, 0, 0, 0, 0, 9, 0, 127, 1, 0);

    // R2: vl of zero ignored
    @(negedge clk);
    vl = 7'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R2 vl zero", out_valid, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule